// File: doc/BRIEF.md
# SHA-256 Block Compression Engine

This block runs the SHA-256 compression function over one 512-bit message block per start request and presents a 256-bit digest. It is iterative. A start pulse loads the block and the starting hash state. The engine then works through the 64 rounds, one per clock cycle, and spends one more cycle adding the working variables back into the stored hash. The result is ready 65 clock cycles after the start edge.

A first-block flag, sampled with the start pulse, picks the starting state. When the flag is high, the engine uses the standard SHA-256 initial hash value. When it is low, the engine continues from the digest that the previous block left behind. A long message is therefore hashed by feeding its blocks one after another, with the flag high only on the first block. Padding and splitting the message into blocks are done upstream. Every block must arrive already padded.

Top module: `sha256_block_core`

## Requirements
- R1: While reset is asserted and right after it is released, `ready_o` is 0 and `digest_o` holds the standard SHA-256 initial hash value, with H0 in the top 32 bits.
- R2: A start with `first_i`=1 on the padded one-block message "abc" yields the standard digest ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad.
- R3: A start with `first_i`=0 chains from the previous digest. The two-block message "abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq" yields 248d6a61 d20638b8 e5c02693 0c3e6039 a33ce459 64ff2167 f6ecedd4 19db06c1.
- R4: `ready_o` rises exactly 65 rising clock edges after the edge that accepts the start pulse.
- R5: A start pulse that arrives while a block is in progress is ignored. The running block finishes on its original schedule, with its original data and flag.
- R6: `ready_o` goes low in the cycle after an accepted start. Once high, `ready_o` and `digest_o` stay unchanged until the next start.
- R7: The 32-bit word in `block_i[511:480]` is message word W0, and later words follow toward the LSB. The digest packs H0 in `digest_o[255:224]` and H7 in `digest_o[31:0]`.
- R8: For arbitrary blocks, each digest equals the SHA-256 compression of the block applied to the selected starting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start request |
| first_i | input | 1 | 1: start from the initial hash value; 0: chain from the stored digest |
| block_i | input | 512 | Padded message block, W0 in the MSBs |
| digest_o | output | 256 | Hash state, H0 in the MSBs |
| ready_o | output | 1 | Digest valid for the last block |

## Verification
Known-answer runs of the single-block "abc" message and of a two-block message show whether the round constants, the rotate amounts and the word order are right. The two-block run also shows whether the second block really chains from the first. Random blocks with random first-block flags are compared against a separate software model, so that first-block and chained starts can be told apart across many data patterns. A second start in the middle of a block, with different data, shows whether a busy start is truly ignored, both in the digest and in the 65-cycle latency.

// File: rtl/sha256_pkg.sv
package sha256_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned N_WIN    = 16;
  localparam int unsigned N_ROUNDS = 64;
  localparam int unsigned N_STATE  = 8;
  localparam int unsigned BLOCK_W  = WORD_W * N_WIN;
  localparam int unsigned DIGEST_W = WORD_W * N_STATE;
  localparam int unsigned RND_W    = $clog2(N_ROUNDS);
  localparam int unsigned CNT_W    = $clog2(N_ROUNDS + 1);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [N_STATE-1:0][WORD_W-1:0] state_t;  // index 0 = a / H0

  localparam word_t K_TAB [N_ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  localparam word_t IV_TAB [N_STATE] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
  };

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_s0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_s1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sha256_ctrl.sv
module sha256_ctrl
  import sha256_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic             fin_o,
  output logic             busy_o,
  output logic [RND_W-1:0] rnd_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = start_i & ~busy_q;
  assign fin_o  = busy_q & (cnt_q == CNT_W'(N_ROUNDS));
  assign step_o = busy_q & ~fin_o;
  assign busy_o = busy_q;
  assign rnd_o  = cnt_q[RND_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (fin_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (step_o) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // busy start must not restart the round counter
  p_busy_start_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && start_i) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N_ROUNDS));
endmodule

// File: rtl/sha256_sched.sv
module sha256_sched
  import sha256_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [BLOCK_W-1:0] block_i,
  output word_t              w_o
);
  word_t win_q [N_WIN];
  word_t w_next;

  // W[t+16] from the window holding W[t..t+15]
  assign w_next = sml_s1(win_q[14]) + win_q[9] + sml_s0(win_q[1]) + win_q[0];
  assign w_o    = win_q[0];

  for (genvar gi = 0; gi < N_WIN; gi++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_q[gi] <= '0;
      end else if (load_i) begin
        win_q[gi] <= block_i[BLOCK_W-1-WORD_W*gi -: WORD_W];
      end else if (step_i) begin
        if (gi == N_WIN - 1) win_q[gi] <= w_next;
        else                 win_q[gi] <= win_q[(gi+1) % N_WIN];
      end
    end
  end

  p_load_word0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (w_o == $past(block_i[BLOCK_W-1 -: WORD_W])));
endmodule

// File: rtl/sha256_round.sv
module sha256_round
  import sha256_pkg::*;
(
  input  state_t st_i,
  input  word_t  w_i,
  input  word_t  k_i,
  output state_t st_o
);
  word_t t1, t2, ch, maj;

  always_comb begin
    ch   = (st_i[4] & st_i[5]) ^ (~st_i[4] & st_i[6]);
    maj  = (st_i[0] & st_i[1]) ^ (st_i[0] & st_i[2]) ^ (st_i[1] & st_i[2]);
    t1   = st_i[7] + big_s1(st_i[4]) + ch + k_i + w_i;
    t2   = big_s0(st_i[0]) + maj;
    st_o = st_i;
    st_o[0] = t1 + t2;
    st_o[1] = st_i[0];
    st_o[2] = st_i[1];
    st_o[3] = st_i[2];
    st_o[4] = st_i[3] + t1;
    st_o[5] = st_i[4];
    st_o[6] = st_i[5];
    st_o[7] = st_i[6];
  end
endmodule

// File: rtl/sha256_block_core.sv
module sha256_block_core
  import sha256_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                first_i,
  input  logic [BLOCK_W-1:0]  block_i,
  output logic [DIGEST_W-1:0] digest_o,
  output logic                ready_o
);
  logic             load, step, fin, busy;
  logic [RND_W-1:0] rnd;
  word_t            w_cur;
  state_t           work_q, hash_q, round_nx, iv_st, seed_st;
  logic             ready_q;

  sha256_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .load_o(load), .step_o(step), .fin_o(fin), .busy_o(busy), .rnd_o(rnd)
  );

  sha256_sched u_sched (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .block_i, .w_o(w_cur)
  );

  sha256_round u_round (
    .st_i(work_q), .w_i(w_cur), .k_i(K_TAB[rnd]), .st_o(round_nx)
  );

  for (genvar gi = 0; gi < N_STATE; gi++) begin : g_state
    assign iv_st[gi] = IV_TAB[gi];
    assign digest_o[DIGEST_W-1-WORD_W*gi -: WORD_W] = hash_q[gi];
  end

  assign seed_st = first_i ? iv_st : hash_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q  <= '0;
      hash_q  <= iv_st;
      ready_q <= 1'b0;
    end else if (load) begin
      work_q  <= seed_st;
      hash_q  <= seed_st;
      ready_q <= 1'b0;
    end else if (step) begin
      work_q  <= round_nx;
    end else if (fin) begin
      for (int i = 0; i < N_STATE; i++) hash_q[i] <= hash_q[i] + work_q[i];
      ready_q <= 1'b1;
    end
  end

  assign ready_o = ready_q;

  // latency monitor for the assertions below
  logic [CNT_W:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lat_q <= '0;
    else if (load) lat_q <= '0;
    else if (busy) lat_q <= lat_q + 1'b1;
  end

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (lat_q == (CNT_W+1)'(N_ROUNDS + 1)));

  p_ready_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy) |=> !ready_o);

  p_ready_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> (ready_o && $stable(digest_o)));

  p_no_ready_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !ready_o);
endmodule

// File: tb/sha256_block_core_tb.sv
module sha256_block_core_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         first = 1'b0;
  logic [511:0] blk = '0;
  logic [255:0] digest;
  logic         ready;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct { logic [255:0] exp; string tag; int c0; } item_t;
  item_t sb_q [$];
  logic [255:0] model_h;

  localparam logic [255:0] IV = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
  localparam logic [31:0] KK [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  sha256_block_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .first_i(first),
    .block_i(blk), .digest_o(digest), .ready_o(ready)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_comp(input logic [255:0] h, input logic [511:0] m);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] t1, t2;
    logic [255:0] r;
    for (int t = 0; t < 16; t++) w[t] = m[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2],17) ^ rr(w[t-2],19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15],7) ^ rr(w[t-15],18) ^ (w[t-15] >> 3)) + w[t-16];
    for (int i = 0; i < 8; i++) v[i] = h[255-32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4],6) ^ rr(v[4],11) ^ rr(v[4],25)) + ((v[4] & v[5]) ^ (~v[4] & v[6])) + KK[t] + w[t];
      t2 = (rr(v[0],2) ^ rr(v[0],13) ^ rr(v[0],22)) + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) r[255-32*i -: 32] = h[255-32*i -: 32] + v[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: pulse start, push expected item
  task automatic send(input logic [511:0] b, input bit f, input string tag);
    item_t it;
    if (f) model_h = IV;
    model_h = ref_comp(model_h, b);
    @(negedge clk);
    start = 1'b1; first = f; blk = b;
    @(negedge clk);
    start = 1'b0;
    it.exp = model_h; it.tag = tag; it.c0 = cyc;
    sb_q.push_back(it);
    chk(ready == 1'b0, "R6 ready low after start", {255'b0, ready}, 256'd0);
  endtask

  task automatic wait_done();
    @(posedge ready);
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare on each rising ready
  initial begin
    logic prev;
    item_t it;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && ready && !prev) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R8 unexpected ready", digest, '0);
        end else begin
          it = sb_q.pop_front();
          chk(digest == it.exp, it.tag, digest, it.exp);
          chk((cyc - it.c0) == 65, "R4 latency", 256'(cyc - it.c0), 256'd65);
        end
      end
      prev = ready;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [511:0] b1, b2, ba, bb, rb;
    logic [255:0] held;
    model_h = IV;
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1 ready in reset", {255'b0, ready}, 256'd0);
    chk(digest == IV, "R1 digest in reset", digest, IV);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b0, "R1 ready after reset", {255'b0, ready}, 256'd0);
    chk(digest == IV, "R1 digest after reset", digest, IV);

    // R2 / R7 known answer
    send({"abc", 8'h80, 416'h0, 64'h18}, 1'b1, "R2 abc vs model");
    wait_done();
    chk(digest == 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad,
        "R2 R7 abc known answer", digest,
        256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);

    // R6 hold
    held = digest;
    repeat (10) @(negedge clk);
    chk(ready == 1'b1, "R6 ready held", {255'b0, ready}, 256'd1);
    chk(digest == held, "R6 digest held", digest, held);

    // R3 two-block chain
    b1 = {"abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq", 8'h80, 56'h0};
    b2 = {448'h0, 64'h1c0};
    send(b1, 1'b1, "R8 block one vs model");
    wait_done();
    send(b2, 1'b0, "R3 chained block vs model");
    wait_done();
    chk(digest == 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1,
        "R3 two-block known answer", digest,
        256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1);

    // R5 start while busy is ignored
    for (int i = 0; i < 16; i++) begin
      ba[32*i +: 32] = $urandom;
      bb[32*i +: 32] = $urandom;
    end
    send(ba, 1'b0, "R5 busy start ignored");
    repeat (20) @(negedge clk);
    start = 1'b1; first = 1'b1; blk = bb;
    @(negedge clk);
    start = 1'b0;
    wait_done();

    // R8 random blocks, random flags
    for (int n = 0; n < 8; n++) begin
      for (int i = 0; i < 16; i++) rb[32*i +: 32] = $urandom;
      send(rb, (n == 0) ? 1'b1 : 1'($urandom), "R8 random block");
      wait_done();
    end

    chk(sb_q.size() == 0, "R8 scoreboard drained", 256'(sb_q.size()), 256'd0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule